// File: doc/BRIEF.md
# Five-Direction Hole Filler

This block sits after a left/right consistency check in a stereo disparity pipeline. It takes a raster-ordered stream of disparity samples, each with a 2-bit status code, and repairs the samples that the check rejected. A sample marked consistent leaves the block untouched. A rejected sample, or hole, is replaced by an order statistic of five neighbours. Two of them come from the current row: the pixel to the left and the pixel to the right. Three come from the row above: up-left, straight up and up-right. The five values are ranked by a combinational odd-even transposition network. An occlusion hole takes the second smallest value, because the background usually has the smaller disparity. A mismatch hole takes the median.

The block holds each sample until the next one arrives, so that the right-hand neighbour is known when the pixel is resolved. A line buffer of `IMG_W` entries stores the already-repaired values of the previous row. A start-of-frame strobe on the first sample restarts the column and row tracking. The median post-filter and the conversion from disparity to depth are separate blocks downstream.

Top module: `hole_filler`

## Requirements
- R1: A sample with status 2'b00 (consistent) is output with its disparity unchanged and status 2'b00.
- R2: A sample with status 2'b10 (occlusion) is output with the second smallest of its five neighbour values (index 1 of the ascending order) and status 2'b00.
- R3: A sample with status 2'b01 (mismatch) is output with the median of its five neighbour values (index 2 of the ascending order) and status 2'b00.
- R4: A sample with status 2'b11 is output with both its disparity and its status unchanged.
- R5: For the pixel at column x of row y, the neighbours are the repaired output at (x-1,y), the raw input disparity at (x+1,y) whatever its status, and the repaired outputs at (x-1,y-1), (x,y-1) and (x+1,y-1).
- R6: A neighbour that lies outside the frame is taken as 0. This covers the whole row above for row 0, the left side for column 0, and the right side for column IMG_W-1.
- R7: Each accepted sample, except the first one after reset, releases exactly one output. The output is for the previously accepted sample and appears with out_valid high in the cycle after the clock edge that accepts the new sample. Idle cycles in between are allowed, and out_valid stays low in every cycle in which no sample was accepted on the previous edge.
- R8: A sample with in_sof high is placed at column 0 of row 0. The pixel still held at that moment is resolved with a right neighbour of 0, even if its row is incomplete.
- R9: While rst_n is low, out_valid is low and any held sample is discarded. The next accepted sample is treated as column 0 of row 0.
- R10: The five neighbour values are ranked into ascending order before the second smallest or the median is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A sample is presented this cycle |
| in_sof | input | 1 | The presented sample is the first of a frame |
| in_flag | input | 2 | Status code: 00 consistent, 10 occlusion, 01 mismatch, 11 pass-through |
| in_disp | input | DW | Input disparity |
| out_valid | output | 1 | A repaired sample is present |
| out_flag | output | 2 | Output status (00 after a fill) |
| out_disp | output | DW | Repaired disparity |

## Verification
The hardest case to reach from the ports is a hole whose five neighbours are themselves the results of earlier fills. In that case a wrong order statistic one row up spreads into every later row. The stimulus therefore runs several frames with dense random mixes of occlusion and mismatch codes, so that chains of fills form across rows. It also truncates a frame in the middle of a row with a new start-of-frame strobe, which forces a pixel to resolve without its right neighbour. A reset in the middle of a frame, with a sample held, checks that nothing stale is released afterwards.

// File: rtl/hf_pkg.sv
package hf_pkg;
    typedef enum logic [1:0] {
        ST_GOOD  = 2'b00,
        ST_MISM  = 2'b01,
        ST_OCCL  = 2'b10,
        ST_THRU  = 2'b11
    } status_e;

    localparam int NB_CNT = 5;
    localparam int IDX_2ND = 1;
    localparam int IDX_MED = 2;
endpackage

// File: rtl/hf_sort5.sv
module hf_sort5 #(
    parameter int DW = 8
) (
    input  logic [4:0][DW-1:0] din,
    output logic [4:0][DW-1:0] dout
);
    localparam int N = hf_pkg::NB_CNT;

    logic [DW-1:0] stg [0:N][0:N-1];

    for (genvar i = 0; i < N; i++) begin : g_io
        assign stg[0][i] = din[i];
        assign dout[i]   = stg[N][i];
    end

    for (genvar p = 0; p < N; p++) begin : g_pass
        localparam int S = p % 2;
        for (genvar i = 0; i < N; i++) begin : g_lane
            if (i >= S && ((i - S) % 2 == 0) && (i + 1 < N)) begin : g_lo
                assign stg[p+1][i] = (stg[p][i] > stg[p][i+1]) ? stg[p][i+1] : stg[p][i];
            end else if (i >= S + 1 && ((i - S) % 2 == 1)) begin : g_hi
                assign stg[p+1][i] = (stg[p][i-1] > stg[p][i]) ? stg[p][i-1] : stg[p][i];
            end else begin : g_keep
                assign stg[p+1][i] = stg[p][i];
            end
        end
    end
endmodule

// File: rtl/hf_linebuf.sv
module hf_linebuf #(
    parameter int DEPTH = 640,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/hole_filler.sv
module hole_filler #(
    parameter int IMG_W = 640,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic [1:0]    in_flag,
    input  logic [DW-1:0] in_disp,
    output logic          out_valid,
    output logic [1:0]    out_flag,
    output logic [DW-1:0] out_disp
);
    import hf_pkg::*;

    localparam int CW = $clog2(IMG_W);
    localparam logic [CW-1:0] LAST_COL = CW'(IMG_W - 1);

    typedef struct packed {
        logic          hv;
        logic [1:0]    hf;
        logic [DW-1:0] hd;
        logic [CW-1:0] hc;
        logic          hr0;
        logic [CW-1:0] nc;
        logic          nr0;
        logic [DW-1:0] left;
        logic [DW-1:0] pab;
        logic          ov;
        logic [1:0]    of;
        logic [DW-1:0] od;
    } state_t;

    state_t s_d, s_q;

    logic              proc_w;
    logic              at_first, at_last;
    logic [DW-1:0]     rd_up, rd_ur;
    logic [CW-1:0]     ur_addr;
    logic [DW-1:0]     n_left, n_right, n_up, n_ul, n_ur;
    logic [4:0][DW-1:0] srt_in, srt_w;
    logic [DW-1:0]     fill_v;
    logic [1:0]        fill_f;
    logic [CW-1:0]     new_c;
    logic              new_r0;
    logic [1:0]        hold_flag_w;
    logic [DW-1:0]     hold_disp_w;

    assign proc_w   = in_valid && s_q.hv;
    assign at_first = (s_q.hc == '0);
    assign at_last  = (s_q.hc == LAST_COL);
    assign ur_addr  = at_last ? s_q.hc : s_q.hc + CW'(1);

    assign n_left  = at_first ? '0 : s_q.left;
    assign n_right = (at_last || in_sof) ? '0 : in_disp;
    assign n_up    = s_q.hr0 ? '0 : rd_up;
    assign n_ul    = (s_q.hr0 || at_first) ? '0 : s_q.pab;
    assign n_ur    = (s_q.hr0 || at_last) ? '0 : rd_ur;
    assign srt_in  = {n_right, n_left, n_ur, n_up, n_ul};

    assign hold_flag_w = s_q.hf;
    assign hold_disp_w = s_q.hd;

    hf_linebuf #(.DEPTH(IMG_W), .DW(DW), .AW(CW)) i_linebuf (
        .clk     (clk),
        .we      (proc_w),
        .waddr   (s_q.hc),
        .wdata   (fill_v),
        .raddr_a (s_q.hc),
        .rdata_a (rd_up),
        .raddr_b (ur_addr),
        .rdata_b (rd_ur)
    );

    hf_sort5 #(.DW(DW)) i_sort (
        .din  (srt_in),
        .dout (srt_w)
    );

    always_comb begin
        s_d = s_q;
        case (status_e'(s_q.hf))
            ST_OCCL: begin fill_v = srt_w[IDX_2ND]; fill_f = ST_GOOD; end
            ST_MISM: begin fill_v = srt_w[IDX_MED]; fill_f = ST_GOOD; end
            default: begin fill_v = s_q.hd;         fill_f = s_q.hf;  end
        endcase

        s_d.ov = proc_w;
        if (proc_w) begin
            s_d.of   = fill_f;
            s_d.od   = fill_v;
            s_d.left = fill_v;
            s_d.pab  = rd_up;
        end

        new_c  = in_sof ? '0 : s_q.nc;
        new_r0 = in_sof ? 1'b1 : s_q.nr0;
        if (in_valid) begin
            s_d.hv  = 1'b1;
            s_d.hf  = in_flag;
            s_d.hd  = in_disp;
            s_d.hc  = new_c;
            s_d.hr0 = new_r0;
            s_d.nc  = (new_c == LAST_COL) ? '0 : new_c + CW'(1);
            s_d.nr0 = (new_c == LAST_COL) ? 1'b0 : new_r0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.nr0 <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.ov;
    assign out_flag  = s_q.of;
    assign out_disp  = s_q.od;
endmodule

// File: rtl/hf_chk.sv
module hf_chk #(
    parameter int DW = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               out_valid,
    input logic [1:0]         out_flag,
    input logic [DW-1:0]      out_disp,
    input logic               proc,
    input logic [1:0]         hold_flag,
    input logic [DW-1:0]      hold_disp,
    input logic [4:0][DW-1:0] srt
);
    p_out_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    p_sorted_r10: assert property (@(posedge clk) disable iff (!rst_n)
        proc |-> (srt[0] <= srt[1] && srt[1] <= srt[2] && srt[2] <= srt[3] && srt[3] <= srt[4]));

    p_good_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (proc && hold_flag == 2'b00) |=> (out_valid && out_flag == 2'b00 && out_disp == $past(hold_disp)));

    p_occl_pick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (proc && hold_flag == 2'b10) |=> (out_flag == 2'b00 && out_disp == $past(srt[1])));

    p_mism_pick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (proc && hold_flag == 2'b01) |=> (out_flag == 2'b00 && out_disp == $past(srt[2])));

    p_thru_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (proc && hold_flag == 2'b11) |=> (out_flag == 2'b11 && out_disp == $past(hold_disp)));
endmodule

bind hole_filler hf_chk #(.DW(DW)) i_hf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_flag  (out_flag),
    .out_disp  (out_disp),
    .proc      (proc_w),
    .hold_flag (hold_flag_w),
    .hold_disp (hold_disp_w),
    .srt       (srt_w)
);

// File: tb/test_hole_filler.sv
module test_hole_filler;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 6;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sof = 1'b0;
    logic [1:0]    in_flag = 2'b00;
    logic [DW-1:0] in_disp = '0;
    logic          out_valid;
    logic [1:0]    out_flag;
    logic [DW-1:0] out_disp;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    int img [0:7][0:W-1];
    bit hv = 0;
    int hx, hy, hf, hd;
    int cx = 0, cy = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hole_filler #(.IMG_W(W), .DW(DW)) i_hole_filler (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_flag(in_flag), .in_disp(in_disp),
        .out_valid(out_valid), .out_flag(out_flag), .out_disp(out_disp)
    );

    task automatic check(input bit ev, input int ef, input int ed, input string tag);
        n_cmp++;
        if (out_valid !== ev || (ev && (out_flag !== 2'(ef) || out_disp !== DW'(ed)))) begin
            n_bad++;
            $display("FAIL %s: actual valid=%0b flag=%0d disp=%0d expected valid=%0b flag=%0d disp=%0d",
                     tag, out_valid, out_flag, out_disp, ev, ef, ed);
        end
    endtask

    // resolve the held pixel; right = raw input of the next pixel, 0 at border or frame start
    task automatic model_step(input bit sof, input int f, input int d,
                              output bit ev, output int ef, output int ed, output string tag);
        int a [5];
        int t, rt, rv;
        string base;
        ev = hv; ef = 0; ed = 0; tag = "R7 idle";
        if (hv) begin
            rt = (hx == W-1 || sof) ? 0 : d;
            a[0] = (hx > 0) ? img[hy%8][hx-1] : 0;
            a[1] = rt;
            a[2] = (hy > 0) ? img[(hy-1)%8][hx] : 0;
            a[3] = (hy > 0 && hx > 0) ? img[(hy-1)%8][hx-1] : 0;
            a[4] = (hy > 0 && hx < W-1) ? img[(hy-1)%8][hx+1] : 0;
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 4 - i; j++)
                    if (a[j] > a[j+1]) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
            case (hf)
                2: begin rv = a[1]; ef = 0; base = "R2 occlusion"; end
                1: begin rv = a[2]; ef = 0; base = "R3 mismatch"; end
                3: begin rv = hd;   ef = 3; base = "R4 passthru"; end
                default: begin rv = hd; ef = 0; base = "R1 consistent"; end
            endcase
            ed = rv;
            img[hy%8][hx] = rv;
            if (sof) tag = {base, " R8 frame-cut"};
            else if (hy == 0 || hx == 0 || hx == W-1) tag = {base, " R6 border"};
            else tag = {base, " R5 interior"};
        end
        if (sof) begin cx = 0; cy = 0; end
        hv = 1; hx = cx; hy = cy; hf = f; hd = d;
        if (cx == W-1) begin cx = 0; cy++; end else cx++;
    endtask

    task automatic send(input bit sof, input int f, input int d);
        bit ev; int ef, ed; string tag;
        in_valid = 1'b1; in_sof = sof; in_flag = 2'(f); in_disp = DW'(d);
        model_step(sof, f, d, ev, ef, ed, tag);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        check(ev, ef, ed, tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            in_valid = 1'b0; in_sof = 1'b0;
            @(posedge clk);
            @(negedge clk);
            check(1'b0, 0, 0, "R7 no output without accept");
        end
    endtask

    task automatic do_reset(input int n);
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(1'b0, 0, 0, "R9 reset");
        end
        rst_n = 1'b1;
        hv = 0; cx = 0; cy = 0;
    endtask

    // rows x W pixels; mode 0 consistent ramp, 1 random holes, 2 random incl. 11
    task automatic frame(input int rows, input int extra, input int mode, input bit gaps);
        int f, d;
        for (int p = 0; p < rows * W + extra; p++) begin
            d = $urandom % 256;
            case (mode)
                0: begin f = 0; d = (p * 7) % 256; end
                1: f = $urandom % 3;
                default: f = $urandom % 4;
            endcase
            send(p == 0, f, d);
            if (gaps && ($urandom % 4 == 0)) idle(1 + $urandom % 2);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog: actual hung expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(3);
        idle(2);
        frame(3, 0, 0, 1'b0);     // R1 plain pass
        frame(4, 0, 1, 1'b0);     // R2 R3 dense holes, back to back
        frame(5, 0, 1, 1'b1);     // R5 with idle gaps
        frame(2, 3, 1, 1'b0);     // R8 frame cut mid row
        frame(3, 0, 2, 1'b1);     // R4 pass-through code mixed in
        send(1'b1, 2, 9);
        send(1'b0, 1, 4);
        send(1'b0, 0, 5);
        do_reset(2);              // R9 reset with a held sample
        idle(1);
        frame(3, 0, 1, 1'b0);
        send(1'b1, 0, 0);         // flush last pixel
        idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule